// File: doc/BRIEF.md
# Shader Co-Issue Pairing and Dispatch

This block sits between instruction fetch and the arithmetic datapath of a pixel shader unit. Every clock it looks at two candidate operations, an older one and a younger one, and decides whether they can go out together. The datapath it feeds has three kinds of resource. There is one scalar special-function slot for reciprocal and reciprocal square root, four multiply channels, and a texture-address slot. The texture slot gets its coordinates only through the multiply channels.

When the two candidates fit the budget and the pairing rules, both issue in the same cycle. The block packs the channels they use, marks which operation owns each channel, and picks each channel's operand source. The source is the register operand, the special-function result produced in the same cycle, or a forwarded pass-through toward the texture slot. When the pair does not fit, only the older operation issues. The younger one is held inside the block and the fetch stage is stalled for one cycle. In that cycle the held operation issues on its own.

All decisions are registered, so the outputs for a pair show up one clock after the pair is presented.

Top module: `sh_coissue_dispatch`

## Requirements
- R1: Class codes are 0 = none, 1 = special function, 2 = multiply, 3 = texture. The outcome for a pair presented in one cycle appears on the outputs after the next rising edge. `iss_vld[0]` marks the first issued operation and `iss_vld[1]` the second. At most two operations issue in any cycle, and the older candidate always takes position 0.
- R2: A special function and a multiply issue together only when the multiply's component count (the number of set bits in its mask) is at most three. A special function with a four-component multiply is not a legal pair.
- R3: A special function may pair with a texture operation of any coordinate count. Two special functions may not pair. A multiply and a texture operation may not pair. Two texture operations may not pair.
- R4: Two multiplies issue together only when their component counts sum to four or fewer, so a 2-component and a 3-component multiply never share a cycle. The first issued operation takes channels 0 upward and the second takes the channels just above those. In `ch_own`, bit i is 1 when channel i belongs to the second issued operation.
- R5: A multiply with its special-result flag set reads operand select 1 (special result) on all of its channels, but only when a special function issues in the same cycle. Otherwise it reads select 0 (register).
- R6: A texture operation occupies as many channels as its mask has set bits and raises `tex_vld`. Without the modify flag, its channels show select 2 (forwarded) and `ch_mul` is 0. With the modify flag, `ch_mul` is 1 on those channels and the select follows the R5 rule.
- R7: For an illegal pair, only the older operation issues and `stall` is 1 in that same output cycle. In the next output cycle the younger operation issues alone in position 0 and `stall` is 0. Candidates presented while `stall` is 1 are ignored.
- R8: A candidate with its valid bit low or with class 0 never issues. If only the younger candidate is live, it issues alone in position 0.
- R9: Synchronous active-high reset clears every issue output, every channel output and `stall`, and discards any held operation.
- R10: A channel not used by an issued operation shows `ch_en`, `ch_mul` and `ch_own` at 0 and select 0. The slot-position class outputs read 0 when that position does not issue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| a_vld | input | 1 | Older candidate valid |
| a_cls | input | 2 | Older candidate class |
| a_mask | input | NCH | Older candidate component mask |
| a_sfu_src | input | 1 | Older candidate reads the special-function result |
| a_tex_mod | input | 1 | Older texture candidate modifies its coordinates in the multiply channels |
| b_vld | input | 1 | Younger candidate valid |
| b_cls | input | 2 | Younger candidate class |
| b_mask | input | NCH | Younger candidate component mask |
| b_sfu_src | input | 1 | Younger candidate reads the special-function result |
| b_tex_mod | input | 1 | Younger texture candidate modifies its coordinates |
| iss_vld | output | 2 | Issue valid for positions 0 and 1 |
| iss0_cls | output | 2 | Class issued in position 0 |
| iss1_cls | output | 2 | Class issued in position 1 |
| ch_en | output | NCH | Channel occupied this cycle |
| ch_mul | output | NCH | Channel performs a multiply |
| ch_own | output | NCH | Channel owned by the position-1 operation |
| ch_sel | output | 2*NCH | Operand select per channel: 0 register, 1 special result, 2 forwarded |
| tex_vld | output | 1 | A texture operation issues this cycle |
| stall | output | 1 | Fetch must hold its candidates for one cycle |

## Verification
If the held-operation register is wrong, the port behaviour shows it within two cycles of an illegal pair. The younger operation either never appears in position 0, or it appears twice, or inputs presented during the stall cycle leak out one edge later. A bad channel split shows up on the very next edge as overlapping or shifted `ch_own` and `ch_en` bits. A wrong pairing rule shows up on that same edge, as a second issue where a stall was due or as a stall where both should have issued. Each check reads the registered outputs one edge after the stimulus and again one edge later, which covers both the immediate decision and the delayed effect of the hold.

// File: rtl/sh_issue_pkg.sv
package sh_issue_pkg;

  typedef enum logic [1:0] {
    OP_NOP = 2'd0,
    OP_SFU = 2'd1,
    OP_MUL = 2'd2,
    OP_TEX = 2'd3
  } op_cls_e;

  localparam logic [1:0] SEL_REG = 2'd0;
  localparam logic [1:0] SEL_SFU = 2'd1;
  localparam logic [1:0] SEL_FWD = 2'd2;

  typedef struct packed {
    logic    live;
    op_cls_e cls;
    logic    sfu_src;
    logic    tex_mod;
  } op_info_t;

  localparam op_info_t NO_OP = '{live: 1'b0, cls: OP_NOP, sfu_src: 1'b0, tex_mod: 1'b0};

endpackage

// File: rtl/sh_cand_decode.sv
module sh_cand_decode
  import sh_issue_pkg::*;
#(
  parameter int NCH = 4,
  parameter int CW  = $clog2(NCH + 1)
) (
  input  logic           vld,
  input  logic [1:0]     cls,
  input  logic [NCH-1:0] mask,
  input  logic           sfu_src,
  input  logic           tex_mod,
  output op_info_t       info,
  output logic [CW-1:0]  cnt
);

  logic [CW-1:0] pop;

  always_comb begin
    pop = '0;
    for (int i = 0; i < NCH; i++) begin
      pop = pop + CW'(mask[i]);
    end
  end

  always_comb begin
    info.cls     = op_cls_e'(cls);
    info.live    = vld && (cls != OP_NOP);
    info.sfu_src = sfu_src;
    info.tex_mod = tex_mod;
    // the special function is scalar and lives outside the multiply channels
    cnt = (info.cls == OP_SFU) ? '0 : pop;
  end

endmodule

// File: rtl/sh_pair_rules.sv
module sh_pair_rules
  import sh_issue_pkg::*;
#(
  parameter int NCH         = 4,
  parameter int CW          = $clog2(NCH + 1),
  parameter int SFU_MUL_MAX = 3
) (
  input  op_cls_e       cls0,
  input  logic [CW-1:0] cnt0,
  input  op_cls_e       cls1,
  input  logic [CW-1:0] cnt1,
  output logic          pair_ok
);

  localparam logic [CW:0] BUDGET   = (CW+1)'(NCH);
  localparam logic [CW:0] SFU_MLIM = (CW+1)'(SFU_MUL_MAX);

  logic [CW:0] sum;
  logic        has_sfu, has_mul, has_tex, two_mul, two_sfu, two_tex;
  logic [CW:0] mul_cnt;

  always_comb begin
    sum     = {1'b0, cnt0} + {1'b0, cnt1};
    has_sfu = (cls0 == OP_SFU) || (cls1 == OP_SFU);
    has_mul = (cls0 == OP_MUL) || (cls1 == OP_MUL);
    has_tex = (cls0 == OP_TEX) || (cls1 == OP_TEX);
    two_mul = (cls0 == OP_MUL) && (cls1 == OP_MUL);
    two_sfu = (cls0 == OP_SFU) && (cls1 == OP_SFU);
    two_tex = (cls0 == OP_TEX) && (cls1 == OP_TEX);
    mul_cnt = (cls0 == OP_MUL) ? {1'b0, cnt0} : {1'b0, cnt1};

    pair_ok = 1'b0;
    if (two_mul)                 pair_ok = (sum <= BUDGET);
    else if (two_sfu || two_tex) pair_ok = 1'b0;
    else if (has_sfu && has_mul) pair_ok = (mul_cnt <= SFU_MLIM);
    else if (has_sfu && has_tex) pair_ok = 1'b1;
  end

endmodule

// File: rtl/sh_hold_reg.sv
module sh_hold_reg
  import sh_issue_pkg::*;
#(
  parameter int NCH = 4,
  parameter int CW  = $clog2(NCH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  op_info_t      load_info,
  input  logic [CW-1:0] load_cnt,
  output logic          held,
  output op_info_t      held_info,
  output logic [CW-1:0] held_cnt
);

  always_ff @(posedge clk) begin
    if (rst) begin
      held      <= 1'b0;
      held_info <= NO_OP;
      held_cnt  <= '0;
    end else if (load) begin
      held      <= 1'b1;
      held_info <= load_info;
      held_cnt  <= load_cnt;
    end else begin
      held      <= 1'b0;
      held_info <= NO_OP;
      held_cnt  <= '0;
    end
  end

endmodule

// File: rtl/sh_chan_alloc.sv
module sh_chan_alloc
  import sh_issue_pkg::*;
#(
  parameter int NCH = 4,
  parameter int CW  = $clog2(NCH + 1)
) (
  input  logic             go0,
  input  logic             go1,
  input  op_info_t         info0,
  input  logic [CW-1:0]    cnt0,
  input  op_info_t         info1,
  input  logic [CW-1:0]    cnt1,
  output logic [NCH-1:0]   en,
  output logic [NCH-1:0]   mul,
  output logic [NCH-1:0]   own,
  output logic [2*NCH-1:0] sel
);

  logic [CW:0] lo1, hi1;
  logic        sfu_with0, sfu_with1;

  always_comb begin
    lo1       = go0 ? {1'b0, cnt0} : '0;
    hi1       = lo1 + (go1 ? {1'b0, cnt1} : '0);
    // a partner special function makes its result available to the other op
    sfu_with0 = go1 && (info1.cls == OP_SFU);
    sfu_with1 = go0 && (info0.cls == OP_SFU);
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    localparam logic [CW:0] IDX = (CW+1)'(i);
    logic     in0, in1, sfu_ok;
    op_info_t owner;

    always_comb begin
      in0    = go0 && (IDX < lo1);
      in1    = go1 && (IDX >= lo1) && (IDX < hi1);
      owner  = in1 ? info1 : info0;
      sfu_ok = owner.sfu_src && (in1 ? sfu_with1 : sfu_with0);

      en[i]          = in0 || in1;
      own[i]         = in1;
      mul[i]         = 1'b0;
      sel[2*i +: 2]  = SEL_REG;
      if (in0 || in1) begin
        if (owner.cls == OP_MUL) begin
          mul[i]        = 1'b1;
          sel[2*i +: 2] = sfu_ok ? SEL_SFU : SEL_REG;
        end else if (owner.cls == OP_TEX) begin
          mul[i]        = owner.tex_mod;
          sel[2*i +: 2] = !owner.tex_mod ? SEL_FWD : (sfu_ok ? SEL_SFU : SEL_REG);
        end
      end
    end
  end

endmodule

// File: rtl/sh_coissue_dispatch.sv
module sh_coissue_dispatch
  import sh_issue_pkg::*;
#(
  parameter int NCH         = 4,
  parameter int SFU_MUL_MAX = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             a_vld,
  input  logic [1:0]       a_cls,
  input  logic [NCH-1:0]   a_mask,
  input  logic             a_sfu_src,
  input  logic             a_tex_mod,
  input  logic             b_vld,
  input  logic [1:0]       b_cls,
  input  logic [NCH-1:0]   b_mask,
  input  logic             b_sfu_src,
  input  logic             b_tex_mod,
  output logic [1:0]       iss_vld,
  output logic [1:0]       iss0_cls,
  output logic [1:0]       iss1_cls,
  output logic [NCH-1:0]   ch_en,
  output logic [NCH-1:0]   ch_mul,
  output logic [NCH-1:0]   ch_own,
  output logic [2*NCH-1:0] ch_sel,
  output logic             tex_vld,
  output logic             stall
);

  localparam int CW = $clog2(NCH + 1);
  localparam int NC = 2;

  logic [NC-1:0]      c_vld, c_sfu, c_mod;
  logic [1:0]         c_cls  [NC];
  logic [NCH-1:0]     c_mask [NC];
  op_info_t           c_info [NC];
  logic [CW-1:0]      c_cnt  [NC];

  assign c_vld  = {b_vld, a_vld};
  assign c_sfu  = {b_sfu_src, a_sfu_src};
  assign c_mod  = {b_tex_mod, a_tex_mod};
  assign c_cls[0]  = a_cls;
  assign c_cls[1]  = b_cls;
  assign c_mask[0] = a_mask;
  assign c_mask[1] = b_mask;

  for (genvar g = 0; g < NC; g++) begin : g_dec
    sh_cand_decode #(.NCH(NCH), .CW(CW)) u_dec (
      .vld     (c_vld[g]),
      .cls     (c_cls[g]),
      .mask    (c_mask[g]),
      .sfu_src (c_sfu[g]),
      .tex_mod (c_mod[g]),
      .info    (c_info[g]),
      .cnt     (c_cnt[g])
    );
  end

  logic          held;
  op_info_t      held_info;
  logic [CW-1:0] held_cnt;
  op_info_t      p0_info, p1_info;
  logic [CW-1:0] p0_cnt, p1_cnt;
  logic          rules_ok, go0, go1, load;

  // choose the operations that compete this cycle
  always_comb begin
    p0_info = NO_OP;
    p0_cnt  = '0;
    p1_info = NO_OP;
    p1_cnt  = '0;
    if (held) begin
      p0_info = held_info;
      p0_cnt  = held_cnt;
    end else if (c_info[0].live) begin
      p0_info = c_info[0];
      p0_cnt  = c_cnt[0];
      p1_info = c_info[1];
      p1_cnt  = c_cnt[1];
    end else begin
      p0_info = c_info[1];
      p0_cnt  = c_cnt[1];
    end
  end

  sh_pair_rules #(.NCH(NCH), .CW(CW), .SFU_MUL_MAX(SFU_MUL_MAX)) u_rules (
    .cls0    (p0_info.cls),
    .cnt0    (p0_cnt),
    .cls1    (p1_info.cls),
    .cnt1    (p1_cnt),
    .pair_ok (rules_ok)
  );

  always_comb begin
    go0  = p0_info.live;
    go1  = p0_info.live && p1_info.live && rules_ok;
    load = p0_info.live && p1_info.live && !rules_ok;
  end

  sh_hold_reg #(.NCH(NCH), .CW(CW)) u_hold (
    .clk       (clk),
    .rst       (rst),
    .load      (load),
    .load_info (p1_info),
    .load_cnt  (p1_cnt),
    .held      (held),
    .held_info (held_info),
    .held_cnt  (held_cnt)
  );

  logic [NCH-1:0]   n_en, n_mul, n_own;
  logic [2*NCH-1:0] n_sel;

  sh_chan_alloc #(.NCH(NCH), .CW(CW)) u_alloc (
    .go0   (go0),
    .go1   (go1),
    .info0 (p0_info),
    .cnt0  (p0_cnt),
    .info1 (p1_info),
    .cnt1  (p1_cnt),
    .en    (n_en),
    .mul   (n_mul),
    .own   (n_own),
    .sel   (n_sel)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      iss_vld  <= '0;
      iss0_cls <= '0;
      iss1_cls <= '0;
      ch_en    <= '0;
      ch_mul   <= '0;
      ch_own   <= '0;
      ch_sel   <= '0;
      tex_vld  <= 1'b0;
      stall    <= 1'b0;
    end else begin
      iss_vld  <= {go1, go0};
      iss0_cls <= go0 ? p0_info.cls : OP_NOP;
      iss1_cls <= go1 ? p1_info.cls : OP_NOP;
      ch_en    <= n_en;
      ch_mul   <= n_mul;
      ch_own   <= n_own;
      ch_sel   <= n_sel;
      tex_vld  <= (go0 && p0_info.cls == OP_TEX) || (go1 && p1_info.cls == OP_TEX);
      stall    <= load;
    end
  end

endmodule

// File: rtl/sh_issue_chk.sv
module sh_issue_chk
  import sh_issue_pkg::*;
#(
  parameter int NCH = 4
) (
  input logic             clk,
  input logic             rst,
  input logic [1:0]       iss_vld,
  input logic [1:0]       iss0_cls,
  input logic [1:0]       iss1_cls,
  input logic [NCH-1:0]   ch_en,
  input logic [NCH-1:0]   ch_mul,
  input logic [NCH-1:0]   ch_own,
  input logic [2*NCH-1:0] ch_sel,
  input logic             tex_vld,
  input logic             stall
);

  logic any_sfu_sel, idle_dirty, pair_sfu, pair_bad;

  always_comb begin
    any_sfu_sel = 1'b0;
    idle_dirty  = 1'b0;
    for (int i = 0; i < NCH; i++) begin
      if (ch_sel[2*i +: 2] == SEL_SFU) any_sfu_sel = 1'b1;
      if (!ch_en[i] && (ch_mul[i] || ch_own[i] || ch_sel[2*i +: 2] != SEL_REG)) idle_dirty = 1'b1;
    end
    pair_sfu = (iss_vld == 2'b11) && (iss0_cls == OP_SFU || iss1_cls == OP_SFU);
    pair_bad = (iss0_cls == OP_SFU && iss1_cls == OP_SFU) ||
               (iss0_cls == OP_TEX && iss1_cls == OP_TEX) ||
               (iss0_cls == OP_MUL && iss1_cls == OP_TEX) ||
               (iss0_cls == OP_TEX && iss1_cls == OP_MUL);
  end

  AST_STALL_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    stall |=> !stall) else $error("stall held too long"); // R7

  AST_STALL_OLDER_ONLY: assert property (@(posedge clk) disable iff (rst)
    stall |-> (iss_vld == 2'b01)) else $error("stall with pair"); // R7

  AST_HELD_ISSUES_ALONE: assert property (@(posedge clk) disable iff (rst)
    stall |=> (iss_vld == 2'b01)) else $error("held op lost"); // R7

  AST_SECOND_NEEDS_FIRST: assert property (@(posedge clk) disable iff (rst)
    iss_vld[1] |-> iss_vld[0]) else $error("position 1 alone"); // R8

  AST_NO_BAD_PAIR: assert property (@(posedge clk) disable iff (rst)
    (iss_vld == 2'b11) |-> !pair_bad) else $error("illegal pair issued"); // R3

  AST_SFU_ROUTE_PAIRED: assert property (@(posedge clk) disable iff (rst)
    any_sfu_sel |-> pair_sfu) else $error("special result routed without partner"); // R5

  AST_IDLE_CH_CLEAN: assert property (@(posedge clk) disable iff (rst)
    !idle_dirty) else $error("idle channel driven"); // R10

  AST_TEX_FLAG_CLASS: assert property (@(posedge clk) disable iff (rst)
    tex_vld |-> ((iss_vld[0] && iss0_cls == OP_TEX) || (iss_vld[1] && iss1_cls == OP_TEX)))
    else $error("tex strobe without texture op"); // R6

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (iss_vld == 2'b00 && !stall && ch_en == '0 && !tex_vld))
    else $error("reset left outputs set"); // R9

endmodule

bind sh_coissue_dispatch sh_issue_chk #(.NCH(NCH)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .iss_vld  (iss_vld),
  .iss0_cls (iss0_cls),
  .iss1_cls (iss1_cls),
  .ch_en    (ch_en),
  .ch_mul   (ch_mul),
  .ch_own   (ch_own),
  .ch_sel   (ch_sel),
  .tex_vld  (tex_vld),
  .stall    (stall)
);

// File: tb/sim_sh_coissue_dispatch.sv
module sim_sh_coissue_dispatch;

  localparam logic [1:0] NOP = 2'd0, SFU = 2'd1, MUL = 2'd2, TEX = 2'd3;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       a_vld = 0, a_sfu_src = 0, a_tex_mod = 0;
  logic       b_vld = 0, b_sfu_src = 0, b_tex_mod = 0;
  logic [1:0] a_cls = 0, b_cls = 0;
  logic [3:0] a_mask = 0, b_mask = 0;
  logic [1:0] iss_vld, iss0_cls, iss1_cls;
  logic [3:0] ch_en, ch_mul, ch_own;
  logic [7:0] ch_sel;
  logic       tex_vld, stall;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  always #4 clk = ~clk;

  sh_coissue_dispatch u0 (
    .clk(clk), .rst(rst),
    .a_vld(a_vld), .a_cls(a_cls), .a_mask(a_mask), .a_sfu_src(a_sfu_src), .a_tex_mod(a_tex_mod),
    .b_vld(b_vld), .b_cls(b_cls), .b_mask(b_mask), .b_sfu_src(b_sfu_src), .b_tex_mod(b_tex_mod),
    .iss_vld(iss_vld), .iss0_cls(iss0_cls), .iss1_cls(iss1_cls),
    .ch_en(ch_en), .ch_mul(ch_mul), .ch_own(ch_own), .ch_sel(ch_sel),
    .tex_vld(tex_vld), .stall(stall)
  );

  task automatic put_a(input logic v, input logic [1:0] c, input logic [3:0] m, input logic s, input logic md);
    a_vld = v; a_cls = c; a_mask = m; a_sfu_src = s; a_tex_mod = md;
  endtask

  task automatic put_b(input logic v, input logic [1:0] c, input logic [3:0] m, input logic s, input logic md);
    b_vld = v; b_cls = c; b_mask = m; b_sfu_src = s; b_tex_mod = md;
  endtask

  task automatic clr_in();
    put_a(0, NOP, 4'b0, 0, 0);
    put_b(0, NOP, 4'b0, 0, 0);
  endtask

  task automatic expect_out(input string req, input logic [1:0] e_iss, input logic [1:0] e_c0,
                            input logic [1:0] e_c1, input logic [3:0] e_en, input logic [3:0] e_mul,
                            input logic [3:0] e_own, input logic [7:0] e_sel, input logic e_tex,
                            input logic e_stall);
    logic [29:0] got, exp;
    got = {iss_vld, iss0_cls, iss1_cls, ch_en, ch_mul, ch_own, ch_sel, tex_vld, stall};
    exp = {e_iss, e_c0, e_c1, e_en, e_mul, e_own, e_sel, e_tex, e_stall};
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got iss=%b c0=%0d c1=%0d en=%b mul=%b own=%b sel=%h tex=%b stall=%b expected iss=%b c0=%0d c1=%0d en=%b mul=%b own=%b sel=%h tex=%b stall=%b",
               req, iss_vld, iss0_cls, iss1_cls, ch_en, ch_mul, ch_own, ch_sel, tex_vld, stall,
               e_iss, e_c0, e_c1, e_en, e_mul, e_own, e_sel, e_tex, e_stall);
    end
  endtask

  task automatic t_reset();
    clr_in();
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    expect_out("R9 reset state", 2'b00, NOP, NOP, 4'h0, 4'h0, 4'h0, 8'h00, 0, 0);
  endtask

  task automatic t_sfu_mul3();
    put_a(1, SFU, 4'b0001, 0, 0);
    put_b(1, MUL, 4'b0111, 1, 0);
    @(negedge clk);
    // R2 R5: pair issues, multiply lanes 0..2 owned by position 1, select special result
    expect_out("R2 R5 sfu+mul3", 2'b11, SFU, MUL, 4'b0111, 4'b0111, 4'b0111, 8'h15, 0, 0);
    clr_in();
    @(negedge clk);
    expect_out("R10 idle after pair", 2'b00, NOP, NOP, 4'h0, 4'h0, 4'h0, 8'h00, 0, 0);
  endtask

  task automatic t_sfu_mul4_stall();
    put_a(1, SFU, 4'b0001, 0, 0);
    put_b(1, MUL, 4'b1111, 1, 0);
    @(negedge clk);
    expect_out("R2 R7 sfu+mul4 older alone", 2'b01, SFU, NOP, 4'h0, 4'h0, 4'h0, 8'h00, 0, 1);
    put_a(1, TEX, 4'b0011, 0, 0);
    put_b(1, TEX, 4'b0001, 0, 0);
    @(negedge clk);
    // R5: special flag ignored without a partner; R7: held op alone
    expect_out("R7 R5 held mul4", 2'b01, MUL, NOP, 4'b1111, 4'b1111, 4'b0000, 8'h00, 0, 0);
    clr_in();
    @(negedge clk);
    expect_out("R7 stall-cycle input ignored", 2'b00, NOP, NOP, 4'h0, 4'h0, 4'h0, 8'h00, 0, 0);
  endtask

  task automatic t_mul_mul();
    put_a(1, MUL, 4'b0011, 0, 0);
    put_b(1, MUL, 4'b1100, 0, 0);
    @(negedge clk);
    expect_out("R4 mul2+mul2", 2'b11, MUL, MUL, 4'b1111, 4'b1111, 4'b1100, 8'h00, 0, 0);
    put_a(1, MUL, 4'b1000, 0, 0);
    put_b(1, MUL, 4'b0111, 0, 0);
    @(negedge clk);
    expect_out("R4 mul1+mul3", 2'b11, MUL, MUL, 4'b1111, 4'b1111, 4'b1110, 8'h00, 0, 0);
    put_a(1, MUL, 4'b0101, 0, 0);
    put_b(1, MUL, 4'b0111, 0, 0);
    @(negedge clk);
    expect_out("R4 mul2+mul3 splits", 2'b01, MUL, NOP, 4'b0011, 4'b0011, 4'b0000, 8'h00, 0, 1);
    clr_in();
    @(negedge clk);
    expect_out("R4 R7 held mul3", 2'b01, MUL, NOP, 4'b0111, 4'b0111, 4'b0000, 8'h00, 0, 0);
  endtask

  task automatic t_tex();
    put_a(1, TEX, 4'b0011, 0, 0);
    put_b(1, SFU, 4'b0001, 0, 0);
    @(negedge clk);
    expect_out("R3 R6 tex+sfu forwarded", 2'b11, TEX, SFU, 4'b0011, 4'b0000, 4'b0000, 8'h0A, 1, 0);
    put_a(1, SFU, 4'b0001, 0, 0);
    put_b(1, TEX, 4'b0111, 1, 1);
    @(negedge clk);
    expect_out("R6 sfu+tex modified", 2'b11, SFU, TEX, 4'b0111, 4'b0111, 4'b0111, 8'h15, 1, 0);
    put_a(1, TEX, 4'b1111, 0, 1);
    put_b(0, NOP, 4'b0, 0, 0);
    @(negedge clk);
    expect_out("R6 tex4 modify from registers", 2'b01, TEX, NOP, 4'b1111, 4'b1111, 4'b0000, 8'h00, 1, 0);
    put_a(1, MUL, 4'b0011, 0, 0);
    put_b(1, TEX, 4'b0001, 0, 0);
    @(negedge clk);
    expect_out("R3 mul+tex splits", 2'b01, MUL, NOP, 4'b0011, 4'b0011, 4'b0000, 8'h00, 0, 1);
    clr_in();
    @(negedge clk);
    expect_out("R3 R6 held tex", 2'b01, TEX, NOP, 4'b0001, 4'b0000, 4'b0000, 8'h02, 1, 0);
  endtask

  task automatic t_sfu_sfu();
    put_a(1, SFU, 4'b0001, 0, 0);
    put_b(1, SFU, 4'b0001, 0, 0);
    @(negedge clk);
    expect_out("R3 sfu+sfu splits", 2'b01, SFU, NOP, 4'h0, 4'h0, 4'h0, 8'h00, 0, 1);
    clr_in();
    @(negedge clk);
    expect_out("R3 held sfu", 2'b01, SFU, NOP, 4'h0, 4'h0, 4'h0, 8'h00, 0, 0);
  endtask

  task automatic t_nop_paths();
    put_a(1, NOP, 4'b1111, 0, 0);
    put_b(1, MUL, 4'b0001, 0, 0);
    @(negedge clk);
    expect_out("R8 nop older, younger first", 2'b01, MUL, NOP, 4'b0001, 4'b0001, 4'b0000, 8'h00, 0, 0);
    put_a(0, MUL, 4'b1111, 0, 0);
    put_b(1, TEX, 4'b0011, 0, 0);
    @(negedge clk);
    expect_out("R8 invalid older", 2'b01, TEX, NOP, 4'b0011, 4'b0000, 4'b0000, 8'h0A, 1, 0);
    put_a(1, MUL, 4'b0011, 0, 0);
    put_b(0, MUL, 4'b0011, 0, 0);
    @(negedge clk);
    expect_out("R1 R8 older only", 2'b01, MUL, NOP, 4'b0011, 4'b0011, 4'b0000, 8'h00, 0, 0);
    clr_in();
    @(negedge clk);
  endtask

  task automatic t_reset_drops_hold();
    put_a(1, MUL, 4'b1111, 0, 0);
    put_b(1, MUL, 4'b0001, 0, 0);
    @(negedge clk);
    expect_out("R4 mul4+mul1 splits", 2'b01, MUL, NOP, 4'b1111, 4'b1111, 4'b0000, 8'h00, 0, 1);
    clr_in();
    rst = 1;
    @(negedge clk);
    expect_out("R9 reset mid-hold", 2'b00, NOP, NOP, 4'h0, 4'h0, 4'h0, 8'h00, 0, 0);
    rst = 0;
    @(negedge clk);
    expect_out("R9 held op discarded", 2'b00, NOP, NOP, 4'h0, 4'h0, 4'h0, 8'h00, 0, 0);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_sfu_mul3();
    t_sfu_mul4_stall();
    t_mul_mul();
    t_tex();
    t_sfu_sfu();
    t_nop_paths();
    t_reset_drops_hold();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      tests++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule